// File: doc/BRIEF.md
# Video Pixel Latency Aligner

This block sits in the pixel clock domain between a decoded incoming video stream and the encoder that transmits it again. Each incoming pixel is registered once and handed to user logic as separate red, green and blue bytes. The same handoff carries the pixel's column and row and a flag that marks visible pixels. User logic has a fixed budget of `LATENCY` pixel-clock cycles to compute replacement colours, which it drives back into the block.

While user logic works, the block carries the pixel's horizontal sync, vertical sync, data-enable and coordinates through a shift register exactly `LATENCY` stages deep. When the replacement colour arrives, it meets the timing information of its own pixel. A final register stage joins the two and drives the encoder side. That stage forces the colour to zero for any pixel that was not visible on entry.

All state runs from the recovered pixel clock, which may stop when no input is present. A synchronous reset empties the pipeline, so no stale sync or enable pulses can leave the block.

Top module: `av_latency_aligner`

## Requirements
- R1: While reset is asserted at a clock edge, that edge clears the following outputs to zero: `usr_active`, every user-side colour and coordinate, and every encoder-side colour, coordinate, sync and enable.
- R2: At each edge the block captures `in_red`, `in_green`, `in_blue`, `in_x`, `in_y` and `in_de`. The captured values appear on `usr_red`, `usr_green`, `usr_blue`, `usr_x`, `usr_y` and `usr_active` one cycle later.
- R3: User logic presents a pixel's replacement colour on `ret_*` `LATENCY` cycles after that pixel appeared on the `usr_*` outputs. If the pixel was visible, the replacement colour shows on `out_red`, `out_green` and `out_blue` one cycle after that.
- R4: `out_de`, `out_hsync`, `out_vsync`, `out_x` and `out_y` carry the values the pixel entered with. They appear `LATENCY`+1 cycles after the pixel appeared on the `usr_*` outputs.
- R5: For a pixel that entered with `in_de` low, `out_red`, `out_green` and `out_blue` are zero whatever `ret_*` holds.
- R6: `LATENCY` defaults to 1. Raising it to 3 moves both the colour-return slot and the control delay to 3 cycles, with no other change.
- R7: Suppose a reset arrives while visible pixels with sync pulses are still inside the block, and the input after reset is idle. Then `out_de`, `out_hsync` and `out_vsync` stay low in every cycle after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_red | input | COLOR_W | Incoming red component |
| in_green | input | COLOR_W | Incoming green component |
| in_blue | input | COLOR_W | Incoming blue component |
| in_x | input | X_W | Incoming pixel column |
| in_y | input | Y_W | Incoming pixel row |
| in_de | input | 1 | Incoming visible-pixel enable |
| in_hsync | input | 1 | Incoming horizontal sync |
| in_vsync | input | 1 | Incoming vertical sync |
| usr_red | output | COLOR_W | Red presented to user logic |
| usr_green | output | COLOR_W | Green presented to user logic |
| usr_blue | output | COLOR_W | Blue presented to user logic |
| usr_x | output | X_W | Column presented to user logic |
| usr_y | output | Y_W | Row presented to user logic |
| usr_active | output | 1 | Presented pixel is visible |
| ret_red | input | COLOR_W | Replacement red from user logic |
| ret_green | input | COLOR_W | Replacement green from user logic |
| ret_blue | input | COLOR_W | Replacement blue from user logic |
| out_red | output | COLOR_W | Red towards the encoder |
| out_green | output | COLOR_W | Green towards the encoder |
| out_blue | output | COLOR_W | Blue towards the encoder |
| out_x | output | X_W | Delayed column towards the encoder |
| out_y | output | Y_W | Delayed row towards the encoder |
| out_de | output | 1 | Delayed visible-pixel enable |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |

## Verification
A pixel driven on the inputs shows on the user-side outputs after one edge. With latency L, it shows on the encoder side after L+2 edges. The bench applies each input at a falling edge and reads the outputs at every later falling edge, so each comparison against the stimulus table uses the index shifted by 1, or by L+2, for that check.

The user model drives the replacement colour for pixel p exactly L cycles after p appeared to the user. Two instances, with L=1 and L=3, run the same table. A directed test resets the block with the pipeline full and then checks that no enable or sync leaves it.

// File: rtl/av_pkg.sv
package av_pkg;

  // Timing controls that travel alongside each pixel.
  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
  } av_ctl_t;

  localparam int AV_CTL_W = 3;

endpackage

// File: rtl/av_shift_delay.sv
module av_shift_delay #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= '0;
          else     stage[s] <= din;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= '0;
          else     stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage[DEPTH-1];

  // A reset leaves nothing in flight at the tail.
  AST_PIPE_FLUSHED: assert property (@(posedge clk) rst |=> dout == '0); // R7

endmodule

// File: rtl/av_input_stage.sv
module av_input_stage
  import av_pkg::*;
#(
  parameter int COLOR_W = 8,
  parameter int X_W     = 11,
  parameter int Y_W     = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COLOR_W-1:0] in_red,
  input  logic [COLOR_W-1:0] in_green,
  input  logic [COLOR_W-1:0] in_blue,
  input  logic [X_W-1:0]     in_x,
  input  logic [Y_W-1:0]     in_y,
  input  av_ctl_t            in_ctl,
  output logic [COLOR_W-1:0] q_red,
  output logic [COLOR_W-1:0] q_green,
  output logic [COLOR_W-1:0] q_blue,
  output logic [X_W-1:0]     q_x,
  output logic [Y_W-1:0]     q_y,
  output av_ctl_t            q_ctl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_red   <= '0;
      q_green <= '0;
      q_blue  <= '0;
      q_x     <= '0;
      q_y     <= '0;
      q_ctl   <= '0;
    end else begin
      q_red   <= in_red;
      q_green <= in_green;
      q_blue  <= in_blue;
      q_x     <= in_x;
      q_y     <= in_y;
      q_ctl   <= in_ctl;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!q_ctl.de && q_red == '0 && q_x == '0)); // R1
  AST_USR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (q_ctl.de == $past(in_ctl.de) && q_x == $past(in_x))); // R2

endmodule

// File: rtl/av_output_merge.sv
module av_output_merge
  import av_pkg::*;
#(
  parameter int COLOR_W = 8,
  parameter int X_W     = 11,
  parameter int Y_W     = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  av_ctl_t            tail_ctl,
  input  logic [X_W-1:0]     tail_x,
  input  logic [Y_W-1:0]     tail_y,
  input  logic [COLOR_W-1:0] ret_red,
  input  logic [COLOR_W-1:0] ret_green,
  input  logic [COLOR_W-1:0] ret_blue,
  output logic [COLOR_W-1:0] out_red,
  output logic [COLOR_W-1:0] out_green,
  output logic [COLOR_W-1:0] out_blue,
  output logic [X_W-1:0]     out_x,
  output logic [Y_W-1:0]     out_y,
  output av_ctl_t            out_ctl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_red   <= '0;
      out_green <= '0;
      out_blue  <= '0;
      out_x     <= '0;
      out_y     <= '0;
      out_ctl   <= '0;
    end else begin
      out_x   <= tail_x;
      out_y   <= tail_y;
      out_ctl <= tail_ctl;
      if (tail_ctl.de) begin
        out_red   <= ret_red;
        out_green <= ret_green;
        out_blue  <= ret_blue;
      end else begin
        out_red   <= '0;
        out_green <= '0;
        out_blue  <= '0;
      end
    end
  end

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_ctl.de |-> (out_red == '0 && out_green == '0 && out_blue == '0)); // R5
  AST_COLOUR_FROM_USER: assert property (@(posedge clk) disable iff (rst)
    tail_ctl.de |=> (out_red == $past(ret_red) && out_blue == $past(ret_blue))); // R3
  AST_CTRL_FOLLOWS_TAIL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_ctl == $past(tail_ctl) && out_y == $past(tail_y))); // R4

endmodule

// File: rtl/av_latency_aligner.sv
module av_latency_aligner
  import av_pkg::*;
#(
  parameter int COLOR_W = 8,
  parameter int X_W     = 11,
  parameter int Y_W     = 10,
  parameter int LATENCY = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COLOR_W-1:0] in_red,
  input  logic [COLOR_W-1:0] in_green,
  input  logic [COLOR_W-1:0] in_blue,
  input  logic [X_W-1:0]     in_x,
  input  logic [Y_W-1:0]     in_y,
  input  logic               in_de,
  input  logic               in_hsync,
  input  logic               in_vsync,
  output logic [COLOR_W-1:0] usr_red,
  output logic [COLOR_W-1:0] usr_green,
  output logic [COLOR_W-1:0] usr_blue,
  output logic [X_W-1:0]     usr_x,
  output logic [Y_W-1:0]     usr_y,
  output logic               usr_active,
  input  logic [COLOR_W-1:0] ret_red,
  input  logic [COLOR_W-1:0] ret_green,
  input  logic [COLOR_W-1:0] ret_blue,
  output logic [COLOR_W-1:0] out_red,
  output logic [COLOR_W-1:0] out_green,
  output logic [COLOR_W-1:0] out_blue,
  output logic [X_W-1:0]     out_x,
  output logic [Y_W-1:0]     out_y,
  output logic               out_de,
  output logic               out_hsync,
  output logic               out_vsync
);

  localparam int BUS_W = AV_CTL_W + X_W + Y_W;

  av_ctl_t            in_ctl;
  av_ctl_t            usr_ctl;
  av_ctl_t            tail_ctl;
  av_ctl_t            o_ctl;
  logic [X_W-1:0]     tail_x;
  logic [Y_W-1:0]     tail_y;
  logic [BUS_W-1:0]   head_bus;
  logic [BUS_W-1:0]   tail_bus;

  assign in_ctl = '{de: in_de, hs: in_hsync, vs: in_vsync};

  av_input_stage #(.COLOR_W(COLOR_W), .X_W(X_W), .Y_W(Y_W)) u_in (
    .clk     (clk),
    .rst     (rst),
    .in_red  (in_red),
    .in_green(in_green),
    .in_blue (in_blue),
    .in_x    (in_x),
    .in_y    (in_y),
    .in_ctl  (in_ctl),
    .q_red   (usr_red),
    .q_green (usr_green),
    .q_blue  (usr_blue),
    .q_x     (usr_x),
    .q_y     (usr_y),
    .q_ctl   (usr_ctl)
  );

  assign usr_active = usr_ctl.de;
  assign head_bus   = {usr_ctl, usr_x, usr_y};

  av_shift_delay #(.WIDTH(BUS_W), .DEPTH(LATENCY)) u_dly (
    .clk (clk),
    .rst (rst),
    .din (head_bus),
    .dout(tail_bus)
  );

  assign {tail_ctl, tail_x, tail_y} = tail_bus;

  av_output_merge #(.COLOR_W(COLOR_W), .X_W(X_W), .Y_W(Y_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .tail_ctl (tail_ctl),
    .tail_x   (tail_x),
    .tail_y   (tail_y),
    .ret_red  (ret_red),
    .ret_green(ret_green),
    .ret_blue (ret_blue),
    .out_red  (out_red),
    .out_green(out_green),
    .out_blue (out_blue),
    .out_x    (out_x),
    .out_y    (out_y),
    .out_ctl  (o_ctl)
  );

  assign out_de    = o_ctl.de;
  assign out_hsync = o_ctl.hs;
  assign out_vsync = o_ctl.vs;

endmodule

// File: tb/tb_av_latency_aligner.sv
`timescale 1ns/100ps
module tb_av_latency_aligner;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [7:0] in_r = '0, in_g = '0, in_b = '0;
  logic [10:0] in_x = '0;
  logic [9:0] in_y = '0;
  logic in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic [7:0] r1_r = '0, r1_g = '0, r1_b = '0;
  logic [7:0] r3_r = '0, r3_g = '0, r3_b = '0;

  logic [7:0] u1_r, u1_g, u1_b, u3_r, u3_g, u3_b;
  logic [10:0] u1_x, u3_x, o1_x, o3_x;
  logic [9:0] u1_y, u3_y, o1_y, o3_y;
  logic u1_a, u3_a;
  logic [7:0] o1_r, o1_g, o1_b, o3_r, o3_g, o3_b;
  logic o1_de, o1_hs, o1_vs, o3_de, o3_hs, o3_vs;

  av_latency_aligner dut (
    .clk(clk), .rst(rst), .in_red(in_r), .in_green(in_g), .in_blue(in_b),
    .in_x(in_x), .in_y(in_y), .in_de(in_de), .in_hsync(in_hs), .in_vsync(in_vs),
    .usr_red(u1_r), .usr_green(u1_g), .usr_blue(u1_b), .usr_x(u1_x), .usr_y(u1_y),
    .usr_active(u1_a), .ret_red(r1_r), .ret_green(r1_g), .ret_blue(r1_b),
    .out_red(o1_r), .out_green(o1_g), .out_blue(o1_b), .out_x(o1_x), .out_y(o1_y),
    .out_de(o1_de), .out_hsync(o1_hs), .out_vsync(o1_vs));

  av_latency_aligner #(.LATENCY(3)) dut3 (
    .clk(clk), .rst(rst), .in_red(in_r), .in_green(in_g), .in_blue(in_b),
    .in_x(in_x), .in_y(in_y), .in_de(in_de), .in_hsync(in_hs), .in_vsync(in_vs),
    .usr_red(u3_r), .usr_green(u3_g), .usr_blue(u3_b), .usr_x(u3_x), .usr_y(u3_y),
    .usr_active(u3_a), .ret_red(r3_r), .ret_green(r3_g), .ret_blue(r3_b),
    .out_red(o3_r), .out_green(o3_g), .out_blue(o3_b), .out_x(o3_x), .out_y(o3_y),
    .out_de(o3_de), .out_hsync(o3_hs), .out_vsync(o3_vs));

  // Vector layout: de[47] hs[46] vs[45] x[44:34] y[33:24] r[23:16] g[15:8] b[7:0]
  localparam int NV = 16;
  localparam logic [47:0] VEC [NV] = '{
    {3'b100, 11'd0,    10'd0,   8'h11, 8'h22, 8'h33},
    {3'b100, 11'd1,    10'd0,   8'hA0, 8'h0B, 8'hC0},
    {3'b100, 11'd2,    10'd0,   8'hFF, 8'h00, 8'h7E},
    {3'b000, 11'd1280, 10'd0,   8'h5A, 8'hA5, 8'h3C},
    {3'b010, 11'd1300, 10'd0,   8'hDE, 8'hAD, 8'hBE},
    {3'b010, 11'd1310, 10'd0,   8'h01, 8'h02, 8'h03},
    {3'b000, 11'd1666, 10'd0,   8'h77, 8'h88, 8'h99},
    {3'b100, 11'd0,    10'd1,   8'h10, 8'h20, 8'h30},
    {3'b100, 11'd1279, 10'd719, 8'hCA, 8'hFE, 8'h42},
    {3'b001, 11'd5,    10'd725, 8'h66, 8'h55, 8'h44},
    {3'b011, 11'd1305, 10'd726, 8'h9F, 8'h8E, 8'h7D},
    {3'b001, 11'd6,    10'd727, 8'hEE, 8'hEE, 8'hEE},
    {3'b100, 11'd640,  10'd360, 8'h80, 8'h40, 8'h20},
    {3'b000, 11'd641,  10'd360, 8'h13, 8'h57, 8'h9B},
    {3'b100, 11'd642,  10'd360, 8'h00, 8'h00, 8'h01},
    {3'b100, 11'd643,  10'd360, 8'hFE, 8'hDC, 8'hBA}
  };

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  function automatic logic [47:0] vget(int k);
    if (k < 0 || k >= NV) return 48'h0;
    return VEC[k];
  endfunction

  // User model: rotate the components (red gets blue, green gets red, blue gets green).
  function automatic logic [23:0] user_fn(logic [47:0] v);
    return {v[7:0], v[23:16], v[15:8]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string who, input logic [47:0] v,
                         input logic de, input logic hs, input logic vs,
                         input logic [10:0] x, input logic [9:0] y,
                         input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    logic [23:0] ec;
    ec = v[47] ? user_fn(v) : 24'h0;
    chk({who, " R4 out controls"}, {de, hs, vs, x, y}, v[47:24]);
    if (v[47]) chk({who, " R3 returned colour"}, {r, g, b}, ec);
    else       chk({who, " R5 blanked colour"}, {r, g, b}, ec);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state after reset edges
    chk("R1 reset user side", {u1_a, u1_r, u1_g, u1_b, u1_x, u1_y}, 64'h0);
    chk("R1 reset out side", {o1_de, o1_hs, o1_vs, o1_r, o1_g, o1_b, o1_x, o1_y}, 64'h0);
    chk("R1 reset out side L3", {o3_de, o3_hs, o3_vs, o3_r, o3_g, o3_b}, 64'h0);
    rst = 1'b0;

    for (int i = 0; i < NV + 8; i++) begin
      logic [47:0] vu, v1, v3, vn;
      logic [23:0] c1, c3;
      if (i > 0) @(negedge clk);
      vu = vget(i - 1);
      chk("R2 user handoff", {u1_a, u1_x, u1_y, u1_r, u1_g, u1_b}, {vu[47], vu[44:0]});
      v1 = vget(i - 3);
      chk_out("L1", v1, o1_de, o1_hs, o1_vs, o1_x, o1_y, o1_r, o1_g, o1_b);
      v3 = vget(i - 5);
      chk_out("R6 L3", v3, o3_de, o3_hs, o3_vs, o3_x, o3_y, o3_r, o3_g, o3_b);
      vn = vget(i);
      {in_de, in_hs, in_vs} = vn[47:45];
      in_x = vn[44:34];
      in_y = vn[33:24];
      {in_r, in_g, in_b} = vn[23:0];
      c1 = user_fn(vget(i - 2));
      c3 = user_fn(vget(i - 4));
      {r1_r, r1_g, r1_b} = c1;
      {r3_r, r3_g, r3_b} = c3;
    end

    // R7: fill the pipeline with visible sync-carrying pixels, then reset.
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      {in_de, in_hs, in_vs} = 3'b111;
      in_x = 11'd100 + 11'(i);
      in_y = 10'd50;
      {in_r, in_g, in_b} = 24'h123456;
      {r1_r, r1_g, r1_b} = 24'hABCDEF;
      {r3_r, r3_g, r3_b} = 24'hABCDEF;
    end
    @(negedge clk);
    rst = 1'b1;
    {in_de, in_hs, in_vs} = 3'b000;
    in_x = '0;
    in_y = '0;
    {in_r, in_g, in_b} = 24'h0;
    @(negedge clk);
    chk("R1 mid-stream reset L1", {u1_a, o1_de, o1_hs, o1_vs, o1_r, o1_g, o1_b}, 64'h0);
    chk("R1 mid-stream reset L3", {u3_a, o3_de, o3_hs, o3_vs, o3_r, o3_g, o3_b}, 64'h0);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R7 no stale pulses L1", {o1_de, o1_hs, o1_vs}, 64'h0);
      chk("R7 no stale pulses L3", {o3_de, o3_hs, o3_vs}, 64'h0);
      chk("R5 idle colour after reset", {o1_r, o1_g, o1_b, o3_r, o3_g, o3_b}, 64'h0);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule